// File: doc/BRIEF.md
# Dual Reset and Interrupt Generator

This block turns supply-health information into system reset and interrupt signals. It owns two reset lines with different release points. The early reset lets part of the system out of reset as soon as one chosen rail is enabled. The late reset waits until the whole power-up sequence is done. Each reset line has its own programmable timeout, which stretches the reset after its last cause goes away. A manual reset pin forces both lines low. The pin is asynchronous and is synchronised inside the block.

The block also drives an interrupt and a health indicator. The interrupt reports a watchdog expiry or a masked rail fault, and it is held inactive while the supply sequencer is stepping rails up or down. The health indicator shows whether any rail is reporting an under- or over-voltage fault. All outputs are active-low logic levels driven from flip-flops.

Top module: `rst_irq_gen`

## Requirements
- R1: `mr_n` passes through two synchronising flip-flops. If `mr_n` is low at rising edge k, both reset outputs are low after edge k+2. They stay low while the synchronised value is low.
- R2: While `seq_done` is low, `rst_b_n` is low after the next rising edge.
- R3: `rst_a_n` is low after the next rising edge while the enable bit `ch_en[ra_sel]` is low. It is also low when `ra_sel` is NCH or larger. Once that bit is high and no other A cause is present, the line is released through its timeout.
- R4: Bit i of `fault` is a reset cause for A only when `ra_mask[i]` is 1, and for B only when `rb_mask[i]` is 1. An unmasked fault bit does not affect that reset line.
- R5: A reset line stays low while a cause is present. It goes high on the (T+1)-th rising edge at which none of its causes is sampled, where T is the value of `ra_tmo` or `rb_tmo` captured at the last edge with a cause present.
- R6: A cause sampled at any edge while a reset is being stretched reloads that reset's counter, so the T+1 count starts again.
- R7: When `seq_active` is low, `irq_n` is low after any edge that samples `wd_expire` high, or samples a fault bit whose `irq_mask` bit is 1. Otherwise `irq_n` is high.
- R8: `irq_n` is high after every edge that samples `seq_active` high, whatever the faults and the watchdog do.
- R9: `healthy_n` is low after an edge only if all bits of `fault` were 0 at that edge. The masks do not affect it.
- R10: While the synchronous reset `rst` is high, both reset outputs are low, and `irq_n` and `healthy_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| seq_active | input | 1 | Sequencer is stepping rails up or down |
| seq_done | input | 1 | Full power-up sequence has completed |
| ch_en | input | NCH | Per-rail enable outputs of the sequencer |
| ra_sel | input | $clog2(NCH) | Index of the rail that releases reset A |
| fault | input | NCH | Per-rail under/over-voltage flag |
| ra_mask | input | NCH | Faults that cause reset A |
| rb_mask | input | NCH | Faults that cause reset B |
| irq_mask | input | NCH | Faults that raise the interrupt |
| wd_expire | input | 1 | Watchdog expiry event |
| ra_tmo | input | TW | Reset A stretch length in cycles |
| rb_tmo | input | TW | Reset B stretch length in cycles |
| rst_a_n | output | 1 | Early reset, active low |
| rst_b_n | output | 1 | Late reset, active low |
| irq_n | output | 1 | Interrupt, active low |
| healthy_n | output | 1 | All rails fault-free, active low |

## Verification
Directed patterns isolate one cause at a time.
- A single release of `seq_done` measures the exact stretch length.
- A fault pulse in the middle of a stretch shows that the counter reloads rather than running on.
- A fault with only B's mask bit set shows that the two lines are independent.
- A manual-reset pulse checks the two-cycle synchroniser latency on entry and the stretch on exit.
- Holding the watchdog high while `seq_active` is set separates suppression from the normal interrupt path.

Seeded random traffic then mixes rare manual resets, fault bursts, mask changes and timeout changes, so that causes overlap. A cycle-level reference model catches any mismatch in ordering or edge counting.

// File: rtl/rig_pkg.sv
package rig_pkg;

    localparam int NCH_DEF     = 6;
    localparam int TW_DEF      = 12;
    localparam int SYNC_STAGES = 2;
    localparam int MAXCH       = 32;
    localparam int NRST        = 2;
    localparam int IDX_A       = 0;
    localparam int IDX_B       = 1;

    typedef logic [MAXCH-1:0] chvec_t;

    // Everything that can hold one reset line low.
    typedef struct packed {
        logic manual;  // synchronised manual reset
        logic rail;    // a masked rail fault
        logic gate;    // release condition not yet met
    } cause_t;

    function automatic logic masked_hit(chvec_t flags, chvec_t mask);
        return |(flags & mask);
    endfunction

    function automatic logic cause_live(cause_t c);
        return c.manual | c.rail | c.gate;
    endfunction

endpackage

// File: rtl/rig_sync.sv
module rig_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rig_stretch.sv
module rig_stretch #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cause,
    input  logic [TW-1:0] tmo,
    output logic          active_o
);
    logic [TW-1:0] cnt;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (cause) begin
            cnt    <= tmo;
            active <= 1'b1;
        end else if (cnt != '0) begin
            cnt    <= cnt - 1'b1;
            active <= 1'b1;
        end else begin
            active <= 1'b0;
        end
    end

    assign active_o = active;
endmodule

// File: rtl/rig_flags.sv
module rig_flags
    import rig_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] fault,
    input  logic [NCH-1:0] irq_mask,
    input  logic           wd_expire,
    input  logic           seq_active,
    output logic           irq_o,
    output logic           healthy_o
);
    logic irq_q, healthy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q     <= 1'b0;
            healthy_q <= 1'b0;
        end else begin
            irq_q     <= ~seq_active &
                         (wd_expire | masked_hit(chvec_t'(fault), chvec_t'(irq_mask)));
            healthy_q <= ~|fault;
        end
    end

    assign irq_o     = irq_q;
    assign healthy_o = healthy_q;
endmodule

// File: rtl/rst_irq_gen.sv
module rst_irq_gen
    import rig_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int TW  = TW_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mr_n,
    input  logic                    seq_active,
    input  logic                    seq_done,
    input  logic [NCH-1:0]          ch_en,
    input  logic [$clog2(NCH)-1:0]  ra_sel,
    input  logic [NCH-1:0]          fault,
    input  logic [NCH-1:0]          ra_mask,
    input  logic [NCH-1:0]          rb_mask,
    input  logic [NCH-1:0]          irq_mask,
    input  logic                    wd_expire,
    input  logic [TW-1:0]           ra_tmo,
    input  logic [TW-1:0]           rb_tmo,
    output logic                    rst_a_n,
    output logic                    rst_b_n,
    output logic                    irq_n,
    output logic                    healthy_n
);
    logic          mr_q;
    logic          gate_a;
    cause_t        cz   [NRST];
    logic [TW-1:0] tmo  [NRST];
    logic          held [NRST];
    logic          irq_act, healthy_act;

    rig_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
        .clk(clk), .rst(rst), .d(mr_n), .q(mr_q)
    );

    // R3: a selected index beyond the rail count never releases reset A
    assign gate_a = (int'(ra_sel) < NCH) ? ch_en[ra_sel] : 1'b0;

    assign cz[IDX_A] = '{manual: ~mr_q,
                         rail:   masked_hit(chvec_t'(fault), chvec_t'(ra_mask)),
                         gate:   ~gate_a};
    assign cz[IDX_B] = '{manual: ~mr_q,
                         rail:   masked_hit(chvec_t'(fault), chvec_t'(rb_mask)),
                         gate:   ~seq_done};
    assign tmo[IDX_A] = ra_tmo;
    assign tmo[IDX_B] = rb_tmo;

    for (genvar g = 0; g < NRST; g++) begin : g_rst
        rig_stretch #(.TW(TW)) u_stretch (
            .clk(clk), .rst(rst),
            .cause(cause_live(cz[g])),
            .tmo(tmo[g]),
            .active_o(held[g])
        );
    end

    rig_flags #(.NCH(NCH)) u_flags (
        .clk(clk), .rst(rst),
        .fault(fault), .irq_mask(irq_mask),
        .wd_expire(wd_expire), .seq_active(seq_active),
        .irq_o(irq_act), .healthy_o(healthy_act)
    );

    assign rst_a_n   = ~held[IDX_A];
    assign rst_b_n   = ~held[IDX_B];
    assign irq_n     = ~irq_act;
    assign healthy_n = ~healthy_act;
endmodule

// File: rtl/rst_irq_gen_chk.sv
module rst_irq_gen_chk #(
    parameter int NCH = 6
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   mr_n,
    input logic                   seq_active,
    input logic                   seq_done,
    input logic [NCH-1:0]         ch_en,
    input logic [$clog2(NCH)-1:0] ra_sel,
    input logic [NCH-1:0]         fault,
    input logic [NCH-1:0]         ra_mask,
    input logic [NCH-1:0]         rb_mask,
    input logic [NCH-1:0]         irq_mask,
    input logic                   wd_expire,
    input logic                   rst_a_n,
    input logic                   rst_b_n,
    input logic                   irq_n,
    input logic                   healthy_n
);
    // R1
    mr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!mr_n, 3) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
        |-> (!rst_a_n && !rst_b_n));

    // R2
    seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !seq_done |=> !rst_b_n);

    // R3
    rail_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(ra_sel) < NCH && !ch_en[ra_sel]) |=> !rst_a_n);

    // R4
    fault_a_chk: assert property (@(posedge clk) disable iff (rst)
        (|(fault & ra_mask)) |=> !rst_a_n);

    // R4
    fault_b_chk: assert property (@(posedge clk) disable iff (rst)
        (|(fault & rb_mask)) |=> !rst_b_n);

    // R7
    wd_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!seq_active && (wd_expire || |(fault & irq_mask))) |=> !irq_n);

    // R8
    seq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        seq_active |=> irq_n);

    // R9
    sick_chk: assert property (@(posedge clk) disable iff (rst)
        (|fault) |=> healthy_n);

    // R9
    well_chk: assert property (@(posedge clk) disable iff (rst)
        (fault == '0) |=> !healthy_n);
endmodule

bind rst_irq_gen rst_irq_gen_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .mr_n(mr_n), .seq_active(seq_active),
    .seq_done(seq_done), .ch_en(ch_en), .ra_sel(ra_sel), .fault(fault),
    .ra_mask(ra_mask), .rb_mask(rb_mask), .irq_mask(irq_mask),
    .wd_expire(wd_expire), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n),
    .irq_n(irq_n), .healthy_n(healthy_n)
);

// File: tb/sim_rst_irq_gen.sv
module sim_rst_irq_gen;
    localparam int NCH = 6;
    localparam int TW  = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst, mr_n, seq_active, seq_done, wd_expire;
    logic [NCH-1:0] ch_en, fault, ra_mask, rb_mask, irq_mask;
    logic [2:0]     ra_sel;
    logic [TW-1:0]  ra_tmo, rb_tmo;
    logic           rst_a_n, rst_b_n, irq_n, healthy_n;

    rst_irq_gen #(.NCH(NCH), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .mr_n(mr_n), .seq_active(seq_active),
        .seq_done(seq_done), .ch_en(ch_en), .ra_sel(ra_sel), .fault(fault),
        .ra_mask(ra_mask), .rb_mask(rb_mask), .irq_mask(irq_mask),
        .wd_expire(wd_expire), .ra_tmo(ra_tmo), .rb_tmo(rb_tmo),
        .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .irq_n(irq_n), .healthy_n(healthy_n)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Cycle-level reference model built from the requirements
    bit m_s1 = 1'b1, m_s2 = 1'b1;
    int m_cnt [2];
    bit m_act [2];
    bit m_irq, m_hl, mdl_ok = 1'b0;

    always @(posedge clk) begin
        bit c [2];
        int t [2];
        if (rst) begin
            m_s1 = 1'b1; m_s2 = 1'b1;
            for (int i = 0; i < 2; i++) begin m_cnt[i] = 0; m_act[i] = 1'b1; end
            m_irq = 1'b0; m_hl = 1'b0; mdl_ok = 1'b1;
        end else begin
            c[0] = !m_s2 || (|(fault & ra_mask)) || !ch_en[ra_sel];
            c[1] = !m_s2 || (|(fault & rb_mask)) || !seq_done;
            t[0] = int'(ra_tmo);
            t[1] = int'(rb_tmo);
            for (int i = 0; i < 2; i++) begin
                if (c[i])              begin m_cnt[i] = t[i]; m_act[i] = 1'b1; end
                else if (m_cnt[i] > 0) begin m_cnt[i]--;      m_act[i] = 1'b1; end
                else                   m_act[i] = 1'b0;
            end
            m_irq = !seq_active && (wd_expire || (|(fault & irq_mask)));
            m_hl  = (fault == '0);
            m_s2 = m_s1;
            m_s1 = mr_n;
        end
    end

    always @(negedge clk) begin
        if (mdl_ok) begin
            chk("R1 R3 R4 R5 R6 rst_a_n model", rst_a_n, !m_act[0]);
            chk("R1 R2 R4 R5 R6 rst_b_n model", rst_b_n, !m_act[1]);
            chk("R7 R8 irq_n model",            irq_n,   !m_irq);
            chk("R9 healthy_n model",           healthy_n, !m_hl);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; mr_n = 1'b1; seq_active = 1'b0; seq_done = 1'b0;
        ch_en = '0; ra_sel = '0; fault = '0; ra_mask = '0; rb_mask = '0;
        irq_mask = '0; wd_expire = 1'b0; ra_tmo = '0; rb_tmo = '0;
        wait_n(3);
        // R10 reset state
        chk("R10 rst_a_n in reset", rst_a_n, 1'b0);
        chk("R10 rst_b_n in reset", rst_b_n, 1'b0);
        chk("R10 irq_n in reset", irq_n, 1'b1);
        chk("R10 healthy_n in reset", healthy_n, 1'b1);
        rst = 1'b0;
        ch_en = '1; rb_tmo = 8'd5;
        wait_n(4);
        chk("R3 rst_a_n released by enabled rail", rst_a_n, 1'b1);
        chk("R2 rst_b_n held before seq_done", rst_b_n, 1'b0);

        // R5 exact stretch of 5
        seq_done = 1'b1;
        wait_n(5);
        chk("R5 rst_b_n low after 5 edges", rst_b_n, 1'b0);
        wait_n(1);
        chk("R5 rst_b_n high after 6 edges", rst_b_n, 1'b1);

        // R6 reload in mid-stretch, R4 independence
        seq_done = 1'b0; wait_n(1); seq_done = 1'b1;
        wait_n(3);
        rb_mask = 6'b000001; fault = 6'b000001;
        wait_n(1);
        fault = '0;
        chk("R4 rst_a_n unaffected by B-only fault", rst_a_n, 1'b1);
        wait_n(5);
        chk("R6 rst_b_n still low after reload", rst_b_n, 1'b0);
        wait_n(1);
        chk("R6 rst_b_n released after reload", rst_b_n, 1'b1);

        // R8 suppression, R7 watchdog
        seq_active = 1'b1; wd_expire = 1'b1;
        wait_n(2);
        chk("R8 irq_n held high while sequencing", irq_n, 1'b1);
        seq_active = 1'b0;
        wait_n(1);
        chk("R7 irq_n low on watchdog", irq_n, 1'b0);
        wd_expire = 1'b0;
        wait_n(1);
        chk("R7 irq_n high with no source", irq_n, 1'b1);

        // R9 health with unmasked fault; R4 no reset effect
        rb_mask = '0;
        fault = 6'b100000;
        wait_n(1);
        chk("R9 healthy_n high on fault", healthy_n, 1'b1);
        chk("R4 rst_b_n unaffected by unmasked fault", rst_b_n, 1'b1);
        chk("R7 irq_n unaffected by unmasked fault", irq_n, 1'b1);
        fault = '0;
        wait_n(1);
        chk("R9 healthy_n low when clean", healthy_n, 1'b0);

        // R1 manual reset through the synchroniser, stretch of 2
        ra_tmo = 8'd2; rb_tmo = 8'd2;
        mr_n = 1'b0;
        wait_n(2);
        chk("R1 rst_a_n not yet low after 2 edges", rst_a_n, 1'b1);
        wait_n(1);
        chk("R1 rst_a_n low after 3 edges", rst_a_n, 1'b0);
        chk("R1 rst_b_n low after 3 edges", rst_b_n, 1'b0);
        mr_n = 1'b1;
        wait_n(4);
        chk("R1 R5 rst_a_n low 4 edges after release", rst_a_n, 1'b0);
        wait_n(1);
        chk("R1 R5 rst_a_n high 5 edges after release", rst_a_n, 1'b1);
        chk("R1 R5 rst_b_n high 5 edges after release", rst_b_n, 1'b1);

        // R3 selected rail drops
        ra_sel = 3'd4; ch_en = 6'b101111; ra_tmo = '0;
        wait_n(1);
        chk("R3 rst_a_n low when selected rail off", rst_a_n, 1'b0);
        ch_en = '1;
        wait_n(1);
        chk("R3 rst_a_n high when selected rail on", rst_a_n, 1'b1);

        // Seeded random traffic against the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            mr_n       = ($urandom % 64) != 0;
            seq_active = ($urandom % 8) == 0;
            seq_done   = ($urandom % 16) != 0;
            ch_en      = (($urandom % 12) == 0) ? NCH'($urandom) : '1;
            ra_sel     = 3'($urandom % NCH);
            fault      = (($urandom % 6) == 0) ? NCH'($urandom) : '0;
            wd_expire  = ($urandom % 10) == 0;
            if ((cyc % 50) == 0) begin
                ra_mask  = NCH'($urandom);
                rb_mask  = NCH'($urandom);
                irq_mask = NCH'($urandom);
                ra_tmo   = TW'($urandom % 8);
                rb_tmo   = TW'($urandom % 8);
            end
            wait_n(1);
        end
        wait_n(2);
        finish_run();
    end
endmodule